// File: doc/BRIEF.md
# Prescaled Wide Timestamp Counter

This block keeps a free-running timestamp that many consumer blocks on the same 100 MHz clock read at once. A programmable ratio sets how often the count steps forward: with a ratio of N, the count advances once for every N enabled clock cycles. The count appears on a registered bus. A one-cycle tick marks each cycle in which that bus shows a new value.

To keep the logic depth short, the block splits the work. The test against the end of the prescaler period is captured in a flip-flop and kept apart from the increment. The wide count is built from two halves that are joined by a registered carry. The low half is delayed by one cycle before it is paired with the high half. As a result, consumers only ever see values the count really held, never a mix of an updated low half with a stale high half. Dropping the enable stops the prescaler and the count together, so the prescaler phase is kept exactly across a pause.

Top module: `tstamp_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the prescaler phase, any pending advance, both count halves, the carry register, `count_o` and `tick_o` are all cleared to zero at that edge, and the current `ratio` is captured as the active period.
- R2: The active period P is the captured ratio, with 0 and 1 both meaning P = 1. With `en` held high, the count advances exactly once every P cycles.
- R3: A cycle with `en` low changes nothing. The prescaler phase, a pending advance and the count all hold, and when `en` returns the period resumes from the same phase.
- R4: With `en` held high, the prescaler reaches the last cycle of its period in some cycle t. The advance is then registered in cycle t+1, and `count_o` shows the new value from cycle t+3 on.
- R5: A new `ratio` value is captured only in the cycle that closes the current period. It never shortens or stretches a period that has already begun.
- R6: Each value on `count_o` is either the previous value or the previous value plus one. This holds in every cycle, including when a carry crosses from the low half into the high half.
- R7: After the all-ones value, `count_o` goes to zero on the next advance, with no stall and no skipped value.
- R8: `tick_o` is high for exactly those cycles in which `count_o` differs from its value in the previous cycle.
- R9: Asserting `rst` in the middle of a run clears everything as in R1. Counting then restarts from zero with a full period at the ratio applied during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes prescaler and count |
| ratio | input | RATIO_W (16) | Prescale ratio; 0 and 1 mean every enabled cycle |
| count_o | output | CNT_W (42) | Registered, coherent timestamp |
| tick_o | output | 1 | One-cycle pulse when `count_o` takes a new value |

## Verification
The bench runs a second copy of the block, built with a narrow 8-bit count split into 4-bit halves. In that copy, carries between the halves and the full wrap to zero happen many times within a short run. A design that paired the halves without delaying the low half would show torn values such as 0x0F followed by 0x00 and then 0x10. A design that dropped the registered carry would lose 16 counts at every crossing. Enable is toggled in the middle of a period and in the cycle that holds a pending advance. A design that froze only the count would then drift in phase, or would lose or double an advance. The ratio is also changed in the middle of a period and during reset, which catches a design that applies a new period at once instead of at the next reload.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

  // Index of the last prescaler cycle for an active period value.
  // Ratios 0 and 1 both give a one-cycle period.
  function automatic logic [31:0] period_last(input logic [31:0] r);
    return (r <= 32'd1) ? 32'd0 : r - 32'd1;
  endfunction

endpackage

// File: rtl/tstamp_prescaler.sv
module tstamp_prescaler #(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  output logic               adv_o
);
  import tstamp_pkg::*;

  logic [RATIO_W-1:0] phase_q;
  logic [RATIO_W-1:0] per_q;
  logic               match_q;
  logic [RATIO_W-1:0] last_idx;
  logic               at_end;

  always_comb begin
    last_idx = RATIO_W'(period_last(32'(per_q)));
    at_end   = (phase_q >= last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      per_q   <= ratio;
      match_q <= 1'b0;
    end else if (en) begin
      match_q <= at_end;
      if (at_end) begin
        phase_q <= '0;
        per_q   <= ratio;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign adv_o = match_q & en;

  // R3: a disabled cycle leaves phase and pending advance untouched
  assert_freeze_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(phase_q) && $stable(match_q)));

  // R5: the active period changes only together with a reload
  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(per_q) |-> (phase_q == '0));

  // R2: the phase never runs past the end of the active period
  assert_range_R2: assert property (@(posedge clk) disable iff (rst)
    phase_q <= last_idx);

endmodule

// File: rtl/tstamp_split_count.sv
module tstamp_split_count #(
  parameter int CNT_W = 42,
  parameter int LO_W  = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [CNT_W-1:0] value_o
);
  localparam int HI_W = CNT_W - LO_W;

  logic [LO_W-1:0] lo_q;
  logic [LO_W-1:0] lo_dly_q;
  logic [HI_W-1:0] hi_q;
  logic            cy_q;
  logic [LO_W:0]   lo_sum;

  always_comb lo_sum = {1'b0, lo_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q     <= '0;
      lo_dly_q <= '0;
      hi_q     <= '0;
      cy_q     <= 1'b0;
    end else begin
      if (adv) begin
        lo_q <= lo_sum[LO_W-1:0];
        cy_q <= lo_sum[LO_W];
      end else begin
        cy_q <= 1'b0;
      end
      hi_q     <= hi_q + HI_W'(cy_q);
      lo_dly_q <= lo_q;
    end
  end

  // High half is already carry-corrected when paired with the delayed low half.
  assign value_o = {hi_q, lo_dly_q};

  // R6: a registered carry only exists right after the low half wrapped
  assert_carry_R6: assert property (@(posedge clk) disable iff (rst)
    cy_q |-> (lo_q == '0));

  // R6: the high half moves only by way of the carry register
  assert_hi_R6: assert property (@(posedge clk) disable iff (rst)
    !cy_q |=> $stable(hi_q));

endmodule

// File: rtl/tstamp_tick_delay.sv
module tstamp_tick_delay #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] pipe_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe_q[i] <= 1'b0;
        else if (i == 0) pipe_q[i] <= d;
        else pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = pipe_q[DEPTH-1];

endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter #(
  parameter int CNT_W   = 42,
  parameter int LO_W    = 21,
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  output logic [CNT_W-1:0]   count_o,
  output logic               tick_o
);
  // advance -> low half -> delayed low half: two stages to the output
  localparam int TICK_LAT = 2;

  logic adv;

  tstamp_prescaler #(.RATIO_W(RATIO_W)) u_presc (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .ratio (ratio),
    .adv_o (adv)
  );

  tstamp_split_count #(.CNT_W(CNT_W), .LO_W(LO_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .value_o (count_o)
  );

  tstamp_tick_delay #(.DEPTH(TICK_LAT)) u_tick (
    .clk (clk),
    .rst (rst),
    .d   (adv),
    .q   (tick_o)
  );

  // R6: a tick moves the published count by exactly one
  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (count_o == CNT_W'($past(count_o) + 1'b1)));

  // R8: without a tick the published count does not move
  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !tick_o |-> $stable(count_o));

  // R7: all ones steps to zero
  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (tick_o && (&$past(count_o))) |-> (count_o == '0));

endmodule

// File: tb/tstamp_counter_test.sv
module tstamp_counter_test;
  localparam int W  = 42;
  localparam int SW = 8;

  typedef struct {
    logic [W-1:0] cnt;
    logic         tick;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic en_i = 1'b0;
  logic [15:0] ratio_i = 16'd1;
  logic [W-1:0]  cnt_big;
  logic          tick_big;
  logic [SW-1:0] cnt_small;
  logic          tick_small;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R1";
  exp_t q[$];

  // model state, advanced from the requirements
  logic [15:0]  m_pc = '0, m_per = '0;
  logic         m_pend = 1'b0, m_t1 = 1'b0, m_tick = 1'b0;
  logic [W-1:0] m_cnt = '0, m_pub = '0;

  always #4 clk = ~clk;

  tstamp_counter uut (
    .clk(clk), .rst(rst_i), .en(en_i), .ratio(ratio_i),
    .count_o(cnt_big), .tick_o(tick_big));

  tstamp_counter #(.CNT_W(SW), .LO_W(4), .RATIO_W(16)) uut_small (
    .clk(clk), .rst(rst_i), .en(en_i), .ratio(ratio_i),
    .count_o(cnt_small), .tick_o(tick_small));

  task automatic step(input logic r, input logic e, input logic [15:0] n);
    logic adv;
    logic [15:0] last;
    exp_t x;
    @(negedge clk);
    rst_i = r; en_i = e; ratio_i = n;
    @(posedge clk);
    if (r) begin
      m_pc = '0; m_per = n; m_pend = 0; m_cnt = '0; m_pub = '0; m_t1 = 0; m_tick = 0;
    end else begin
      adv    = m_pend & e;           // R4: advance one cycle after period end
      m_pub  = m_cnt;                // R6: published value lags true value
      m_tick = m_t1;                 // R8
      m_t1   = adv;
      m_cnt  = m_cnt + W'(adv);      // R7: natural wrap
      if (e) begin                   // R3: nothing moves while disabled
        last   = (m_per <= 16'd1) ? 16'd0 : m_per - 16'd1;  // R2
        m_pend = (m_pc >= last);
        if (m_pc >= last) begin m_pc = '0; m_per = n; end   // R5
        else m_pc = m_pc + 16'd1;
      end
    end
    x.cnt = m_pub; x.tick = m_tick; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic run(input int cycles, input logic e, input logic [15:0] n);
    for (int i = 0; i < cycles; i++) step(1'b0, e, n);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        x = q.pop_front();
        checks += 3;
        if (cnt_big !== x.cnt) begin
          fails++;
          $display("FAIL %s wide count act=%h exp=%h", x.tag, cnt_big, x.cnt);
        end
        if (cnt_small !== x.cnt[SW-1:0]) begin
          fails++;
          $display("FAIL %s narrow count act=%h exp=%h", x.tag, cnt_small, x.cnt[SW-1:0]);
        end
        if (tick_big !== x.tick || tick_small !== x.tick) begin
          fails++;
          $display("FAIL %s tick act=%b/%b exp=%b", x.tag, tick_big, tick_small, x.tick);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, ratio captured during reset
    tag = "R1";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 16'd3);
    run(4, 1'b0, 16'd3);
    // R4: latency from period end to published value, ratio 3
    tag = "R4";
    run(12, 1'b1, 16'd3);
    // R2: every enabled cycle for ratio 1 and 0; R6 half carries in narrow copy
    tag = "R2";
    run(40, 1'b1, 16'd1);
    run(40, 1'b1, 16'd0);
    tag = "R6";
    run(60, 1'b1, 16'd1);
    // R5: ratio changes mid-period
    tag = "R5";
    run(2, 1'b1, 16'd5);
    run(3, 1'b1, 16'd9);
    run(40, 1'b1, 16'd7);
    run(3, 1'b1, 16'd2);
    run(20, 1'b1, 16'd4);
    // R3: enable toggled in various phases, including pending-advance cycles
    tag = "R3";
    for (int i = 0; i < 30; i++) begin
      run(i % 5 + 1, 1'b1, 16'd4);
      run(i % 3 + 1, 1'b0, 16'd4);
    end
    for (int i = 0; i < 40; i++) step(1'b0, i[0], 16'd1);
    // R7: run the narrow copy through several full wraps
    tag = "R7";
    run(700, 1'b1, 16'd1);
    // R8: long period, ticks must stay single
    tag = "R8";
    run(60, 1'b1, 16'd11);
    // R9: reset in the middle of a run with a new ratio
    tag = "R9";
    run(5, 1'b1, 16'd2);
    step(1'b1, 1'b1, 16'd6);
    step(1'b1, 1'b1, 16'd6);
    run(30, 1'b1, 16'd2);
    run(4, 1'b0, 16'd2);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule